// File: doc/BRIEF.md
# Fractional-N Divider Sequencer

This block produces the feedback divide ratio of a fractional-N frequency synthesizer, one new value per reference clock. Software writes an integer setting, a 16-bit carrier fraction, a signed trim and an FSK deviation into shadow registers through a byte-wide write port. An explicit apply write moves the whole set into the working registers in one edge. The carrier fraction, the trim and the signed deviation are added into one fractional word. If that sum leaves the range 0 to 63999, it carries into the integer part or borrows from it. The integer part is the integer setting plus a fixed 24.

A third-order noise-shaping modulator turns the fractional word into a dithered integer correction. It is built from three cascaded accumulators that wrap at 64000. The correction is added to the integer part and the result is registered onto `div_ratio`. A serial data input chooses, on every edge, whether the deviation is added to the fraction or taken from it. This puts frequency-shift keying inside the loop. A band flag drives the output halving stage, which lies outside the loop.

Top module: `fracn_div_seq`

## Requirements
- R1: After reset, `div_ratio` is 45 and `band_high` is 1. The reset setting is integer 21, carrier 48000, trim 0, deviation 0 and high band.
- R2: Writes to addresses 0 to 5 change neither `div_ratio` nor `band_high` until an apply write arrives. Address 0 holds bit 5 = high band and bits 4:0 = integer. Address 1 holds the carrier high byte and address 2 the carrier low byte. Address 3 holds trim bits 7:0 and address 4 bits 1:0 hold trim bits 9:8. Address 5 holds the deviation.
- R3: A write to address 7 applies every shadow field on the same edge. It restarts the modulator from zero. On the next cycle `div_ratio` equals the new base ratio, which is the integer + 24 + the carry/borrow adjustment.
- R4: An integer field written above 23 is stored as 23.
- R5: After an apply or a reset, hold the inputs constant. Let D be the running sum of (`div_ratio` − base) over n cycles and S the sum of the fractional words used. Then 64000·D − S stays above −128000 and at most 128000. Over a window of 64000 cycles, D lies within −1..+2 of the fractional word.
- R6: Every cycle that does not follow an apply, `div_ratio` lies within base−3 to base+4.
- R7: The 10-bit trim is two's complement and is added to the carrier word.
- R8: When carrier + trim ± deviation is 64000 or more, the base gains 1 and the fraction is the sum − 64000. When the sum is below 0, the base loses 1 and the fraction is the sum + 64000.
- R9: With `fsk_data` = 1 on an edge the deviation is added to the fraction. With `fsk_data` = 0 it is subtracted.
- R10: `band_high` follows the applied bit 5 of address 0 and has no effect on `div_ratio`.
- R11: With a fractional word of 0, `div_ratio` equals the base on every cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock, also the modulator clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Write strobe for the setting port |
| wr_addr | input | 3 | Setting address (0–5 fields, 7 apply) |
| wr_data | input | 8 | Write data byte |
| fsk_data | input | 1 | Serial modulation bit, sampled every edge |
| div_ratio | output | 7 | Registered divide ratio for the current reference cycle |
| band_high | output | 1 | Applied band flag for the output halving stage |

## Verification
The hardest state to reach from the ports is the modulator's long-run accuracy. An error in the third stage or in the cancellation terms can leave every single sample inside the legal window of R6 while the average drifts. The stimulus therefore restarts the modulator with an apply, or starts it from reset, and holds the inputs steady. It then sums the ratio over thousands of cycles and compares the sum with the fractional words fed in. This includes one full 64000-cycle window and a run in which the data bit toggles every cycle. The carry and borrow paths are reached by pairing carriers near 0 and 64000 with the largest trims and deviations.

// File: rtl/fnds_pkg.sv
package fnds_pkg;
    parameter int INT_W   = 5;
    parameter int CAR_W   = 16;
    parameter int OFF_W   = 10;
    parameter int DEV_W   = 8;
    parameter int DIV_W   = 7;
    parameter int ADDR_W  = 3;
    parameter int DATA_W  = 8;
    parameter int INT_MAX = 23;
    parameter int INT_OFS = 24;
    parameter int MOD     = 64000;
    // cancellation network below is written for exactly three stages
    parameter int ORDER   = 3;
    parameter int CORR_W  = 4;

    localparam int ACC_W = $clog2(MOD);
    localparam int SUM_W = CAR_W + 2;
    localparam int BASE_W = DIV_W + 1;
    localparam int BAND_BIT = INT_W;

    localparam logic [ADDR_W-1:0] A_BAND   = ADDR_W'(0);
    localparam logic [ADDR_W-1:0] A_CAR_HI = ADDR_W'(1);
    localparam logic [ADDR_W-1:0] A_CAR_LO = ADDR_W'(2);
    localparam logic [ADDR_W-1:0] A_OFF_LO = ADDR_W'(3);
    localparam logic [ADDR_W-1:0] A_OFF_HI = ADDR_W'(4);
    localparam logic [ADDR_W-1:0] A_DEV    = ADDR_W'(5);
    localparam logic [ADDR_W-1:0] A_APPLY  = ADDR_W'(7);

    typedef struct packed {
        logic             band_hi;
        logic [INT_W-1:0] int_f;
        logic [CAR_W-1:0] car;
        logic [OFF_W-1:0] off;
        logic [DEV_W-1:0] dev;
    } cfg_t;

    localparam cfg_t CFG_RST = '{
        band_hi: 1'b1,
        int_f:   INT_W'(21),
        car:     CAR_W'(16'hBB80),
        off:     '0,
        dev:     '0
    };
endpackage

// File: rtl/fnds_regs.sv
module fnds_regs
    import fnds_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    output logic              apply_o,
    output logic              act_band_o,
    output logic [INT_W-1:0]  act_int_o,
    output logic [INT_W-1:0]  nxt_int_o,
    output logic [CAR_W-1:0]  nxt_car_o,
    output logic [OFF_W-1:0]  nxt_off_o,
    output logic [DEV_W-1:0]  nxt_dev_o
);
    typedef struct packed {
        cfg_t shadow;
        cfg_t active;
    } reg_st_t;

    reg_st_t st_d, st_q;
    logic    apply;

    always_comb begin
        st_d  = st_q;
        apply = wr_en && (wr_addr == A_APPLY);
        if (wr_en) begin
            case (wr_addr)
                A_BAND: begin
                    st_d.shadow.band_hi = wr_data[BAND_BIT];
                    st_d.shadow.int_f   = (wr_data[INT_W-1:0] > INT_W'(INT_MAX))
                                          ? INT_W'(INT_MAX) : wr_data[INT_W-1:0];
                end
                A_CAR_HI: st_d.shadow.car[CAR_W-1:DATA_W] = wr_data[CAR_W-DATA_W-1:0];
                A_CAR_LO: st_d.shadow.car[DATA_W-1:0]     = wr_data;
                A_OFF_LO: st_d.shadow.off[DATA_W-1:0]     = wr_data;
                A_OFF_HI: st_d.shadow.off[OFF_W-1:DATA_W] = wr_data[OFF_W-DATA_W-1:0];
                A_DEV:    st_d.shadow.dev                 = wr_data[DEV_W-1:0];
                default:  ;
            endcase
        end
        if (apply) begin
            st_d.active = st_q.shadow;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '{shadow: CFG_RST, active: CFG_RST};
        end else begin
            st_q <= st_d;
        end
    end

    assign apply_o    = apply;
    assign act_band_o = st_q.active.band_hi;
    assign act_int_o  = st_q.active.int_f;
    // settings that take effect at this edge: the shadow on apply, else the active set
    assign nxt_int_o  = st_d.active.int_f;
    assign nxt_car_o  = st_d.active.car;
    assign nxt_off_o  = st_d.active.off;
    assign nxt_dev_o  = st_d.active.dev;
endmodule

// File: rtl/fnds_frac.sv
module fnds_frac
    import fnds_pkg::*;
(
    input  logic [CAR_W-1:0]  car_i,
    input  logic [OFF_W-1:0]  off_i,
    input  logic [DEV_W-1:0]  dev_i,
    input  logic              fsk_i,
    output logic [ACC_W-1:0]  frac_o,
    output logic signed [1:0] adj_o
);
    localparam logic signed [SUM_W-1:0] MOD_S = SUM_W'(MOD);

    logic signed [SUM_W-1:0] car_x, off_x, dev_x, total;

    always_comb begin
        car_x = $signed({{(SUM_W-CAR_W){1'b0}}, car_i});
        off_x = $signed({{(SUM_W-OFF_W){off_i[OFF_W-1]}}, off_i});
        dev_x = $signed({{(SUM_W-DEV_W){1'b0}}, dev_i});
        total = car_x + off_x + (fsk_i ? dev_x : -dev_x);
        if (total < 0) begin
            frac_o = ACC_W'(total + MOD_S);
            adj_o  = -2'sd1;
        end else if (total >= MOD_S) begin
            frac_o = ACC_W'(total - MOD_S);
            adj_o  = 2'sd1;
        end else begin
            frac_o = ACC_W'(total);
            adj_o  = 2'sd0;
        end
    end
endmodule

// File: rtl/fnds_mash.sv
module fnds_mash
    import fnds_pkg::*;
(
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     clear_i,
    input  logic [ACC_W-1:0]         frac_i,
    output logic signed [CORR_W-1:0] corr_o
);
    typedef struct packed {
        logic [ORDER-1:0][ACC_W-1:0] acc;
        logic                        c2z;
        logic                        c3z;
        logic                        c3zz;
    } mash_st_t;

    mash_st_t st_d, st_q;

    logic [ORDER:0][ACC_W-1:0] chain;
    logic [ORDER-1:0]          carry;

    assign chain[0] = frac_i;

    for (genvar g = 0; g < ORDER; g++) begin : g_stage
        logic [ACC_W:0] sum;
        assign sum        = {1'b0, st_q.acc[g]} + {1'b0, chain[g]};
        assign carry[g]   = (sum >= (ACC_W+1)'(MOD));
        assign chain[g+1] = carry[g] ? ACC_W'(sum - (ACC_W+1)'(MOD)) : sum[ACC_W-1:0];
    end

    always_comb begin
        // y = c1 + (1 - z^-1) c2 + (1 - z^-1)^2 c3, modulo 2^CORR_W
        corr_o = {{(CORR_W-1){1'b0}}, carry[0]}
               + {{(CORR_W-1){1'b0}}, carry[1]}
               - {{(CORR_W-1){1'b0}}, st_q.c2z}
               + {{(CORR_W-1){1'b0}}, carry[2]}
               - {{(CORR_W-2){1'b0}}, st_q.c3z, 1'b0}
               + {{(CORR_W-1){1'b0}}, st_q.c3zz};

        st_d = st_q;
        if (clear_i) begin
            st_d = '0;
        end else begin
            for (int k = 0; k < ORDER; k++) begin
                st_d.acc[k] = chain[k+1];
            end
            st_d.c2z  = carry[1];
            st_d.c3z  = carry[2];
            st_d.c3zz = st_q.c3z;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end
endmodule

// File: rtl/fracn_div_seq.sv
module fracn_div_seq
    import fnds_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              fsk_data,
    output logic [DIV_W-1:0]  div_ratio,
    output logic              band_high
);
    localparam logic [DIV_W-1:0] DIV_RST = DIV_W'(INT_OFS) + DIV_W'(CFG_RST.int_f);

    typedef struct packed {
        logic [DIV_W-1:0] div;
    } top_st_t;

    top_st_t st_d, st_q;

    logic                     apply;
    logic                     act_band;
    logic [INT_W-1:0]         act_int;
    logic [INT_W-1:0]         nxt_int;
    logic [CAR_W-1:0]         nxt_car;
    logic [OFF_W-1:0]         nxt_off;
    logic [DEV_W-1:0]         nxt_dev;
    logic [ACC_W-1:0]         frac;
    logic signed [1:0]        adj;
    logic signed [CORR_W-1:0] corr;
    logic signed [BASE_W-1:0] n_base;
    logic signed [BASE_W-1:0] n_full;

    fnds_regs u_regs (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_en      (wr_en),
        .wr_addr    (wr_addr),
        .wr_data    (wr_data),
        .apply_o    (apply),
        .act_band_o (act_band),
        .act_int_o  (act_int),
        .nxt_int_o  (nxt_int),
        .nxt_car_o  (nxt_car),
        .nxt_off_o  (nxt_off),
        .nxt_dev_o  (nxt_dev)
    );

    fnds_frac u_frac (
        .car_i  (nxt_car),
        .off_i  (nxt_off),
        .dev_i  (nxt_dev),
        .fsk_i  (fsk_data),
        .frac_o (frac),
        .adj_o  (adj)
    );

    fnds_mash u_mash (
        .clk     (clk),
        .rst_n   (rst_n),
        .clear_i (apply),
        .frac_i  (frac),
        .corr_o  (corr)
    );

    always_comb begin
        n_base = $signed({{(BASE_W-INT_W){1'b0}}, nxt_int})
               + BASE_W'(INT_OFS)
               + {{(BASE_W-2){adj[1]}}, adj};
        n_full = n_base + {{(BASE_W-CORR_W){corr[CORR_W-1]}}, corr};
        st_d.div = apply ? DIV_W'(n_base) : DIV_W'(n_full);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '{div: DIV_RST};
        end else begin
            st_q <= st_d;
        end
    end

    assign div_ratio = st_q.div;
    assign band_high = act_band;
endmodule

// File: rtl/fnds_checker.sv
module fnds_checker
    import fnds_pkg::*;
(
    input logic                     clk,
    input logic                     rst_n,
    input logic                     apply,
    input logic [DIV_W-1:0]         div_ratio,
    input logic signed [BASE_W-1:0] n_base,
    input logic [INT_W-1:0]         int_act,
    input logic [ACC_W-1:0]         frac,
    input logic                     band_high
);
    logic signed [BASE_W-1:0] div_s;
    assign div_s = $signed({1'b0, div_ratio});

    p_int_clamped_r4: assert property (@(posedge clk) disable iff (!rst_n)
        int_act <= INT_W'(INT_MAX));

    p_frac_in_range_r8: assert property (@(posedge clk) disable iff (!rst_n)
        frac < ACC_W'(MOD));

    p_apply_base_r3: assert property (@(posedge clk) disable iff (!rst_n)
        apply |=> div_s == $past(n_base));

    p_corr_window_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !apply |=> ((div_s - $past(n_base)) >= -BASE_W'(3)) &&
                   ((div_s - $past(n_base)) <=  BASE_W'(4)));

    p_hold_without_apply_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !apply |=> $stable(band_high) && $stable(int_act));
endmodule

bind fracn_div_seq fnds_checker u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .apply     (apply),
    .div_ratio (div_ratio),
    .n_base    (n_base),
    .int_act   (act_int),
    .frac      (frac),
    .band_high (band_high)
);

// File: tb/fracn_div_seq_test.sv
module fracn_div_seq_test;
    localparam int M = 64000;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wr_en = 1'b0;
    logic [2:0] wr_addr = '0;
    logic [7:0] wr_data = '0;
    logic       fsk_data = 1'b0;
    logic [6:0] div_ratio;
    logic       band_high;

    int n_chk = 0;
    int n_err = 0;

    always #4 clk = ~clk;

    fracn_div_seq uut (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (wr_en),
        .wr_addr   (wr_addr),
        .wr_data   (wr_data),
        .fsk_data  (fsk_data),
        .div_ratio (div_ratio),
        .band_high (band_high)
    );

    typedef struct packed {
        logic [4:0]  intf;
        logic        hb;
        logic [15:0] car;
        logic [9:0]  off;
        logic [7:0]  dev;
        logic        fsk;
        logic [6:0]  exp_n;
        logic [15:0] exp_f;
    } vec_t;

    localparam int NV = 10;
    localparam vec_t VECS [NV] = '{
        '{5'd21, 1'b1, 16'd48000, 10'd0,     8'd0,   1'b0, 7'd45, 16'd48000}, // plain
        '{5'd0,  1'b0, 16'd1,     10'd0,     8'd0,   1'b0, 7'd24, 16'd1},     // smallest step
        '{5'd31, 1'b1, 16'd32000, 10'd0,     8'd0,   1'b0, 7'd47, 16'd32000}, // R4 clamp
        '{5'd10, 1'b0, 16'd63990, 10'd20,    8'd0,   1'b0, 7'd35, 16'd10},    // R8 carry
        '{5'd10, 1'b1, 16'd5,     10'h3F6,   8'd0,   1'b0, 7'd33, 16'd63995}, // R7 R8 borrow
        '{5'd5,  1'b0, 16'd30000, 10'h3FF,   8'd100, 1'b1, 7'd29, 16'd30099}, // R9 up
        '{5'd5,  1'b0, 16'd30000, 10'h3FF,   8'd100, 1'b0, 7'd29, 16'd29899}, // R9 down
        '{5'd23, 1'b1, 16'd65535, 10'd511,   8'd255, 1'b1, 7'd48, 16'd2301},  // R8 top
        '{5'd0,  1'b0, 16'd0,     10'h200,   8'd255, 1'b0, 7'd23, 16'd63233}, // R8 bottom
        '{5'd12, 1'b0, 16'd0,     10'd0,     8'd0,   1'b0, 7'd36, 16'd0}      // R11 flat
    };

    task automatic chk(input bit ok, input string req, input longint act, input longint exp);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [7:0] d);
        wr_en   = 1'b1;
        wr_addr = a;
        wr_data = d;
        @(negedge clk);
        wr_en   = 1'b0;
    endtask

    task automatic load(input logic [4:0] intf, input logic hb, input logic [15:0] car,
                        input logic [9:0] off, input logic [7:0] dev);
        wr(3'd0, {2'b00, hb, intf});
        wr(3'd1, car[15:8]);
        wr(3'd2, car[7:0]);
        wr(3'd3, off[7:0]);
        wr(3'd4, {6'b0, off[9:8]});
        wr(3'd5, dev);
    endtask

    // runs ncyc cycles after a modulator restart and checks R5, R6, R11
    task automatic run_window(input int ncyc, input int n_exp, input int f1, input int f0,
                              input bit toggle, input bit dbit, input bit full);
        longint dsum = 0;
        longint fsum = 0;
        longint e;
        int     d;
        int     worst_d = 0;
        longint worst_e = 0;
        bit     rng_bad = 0, bnd_bad = 0, flat_bad = 0;
        for (int n = 1; n <= ncyc; n++) begin
            bit b;
            b = toggle ? n[0] : dbit;
            fsk_data = b;
            fsum += b ? f1 : f0;
            @(negedge clk);
            d = int'(div_ratio) - n_exp;
            dsum += d;
            if (d < -3 || d > 4) begin rng_bad = 1; worst_d = d; end
            e = dsum * M - fsum;
            if (e <= -2 * M || e > 2 * M) begin bnd_bad = 1; worst_e = e; end
            if (f1 == 0 && f0 == 0 && d != 0) flat_bad = 1;
        end
        chk(!rng_bad, "R6 per-cycle window", worst_d, 0);
        chk(!bnd_bad, "R5 running average", worst_e, 0);
        if (f1 == 0 && f0 == 0) chk(!flat_bad, "R11 flat ratio", dsum, 0);
        if (full) chk(dsum - fsum / M >= -1 && dsum - fsum / M <= 2,
                      "R5 full window sum", dsum, fsum / M);
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        n_err++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        // R1 reset state
        chk(div_ratio == 7'd45, "R1 reset ratio", div_ratio, 45);
        chk(band_high == 1'b1,  "R1 reset band", band_high, 1);
        run_window(M, 45, 48000, 48000, 1'b0, 1'b0, 1'b1);

        // table walk: R3 base after apply, R10 band, R4 R7 R8 R9 R11 per row
        for (int i = 0; i < NV; i++) begin
            fsk_data = VECS[i].fsk;
            load(VECS[i].intf, VECS[i].hb, VECS[i].car, VECS[i].off, VECS[i].dev);
            wr(3'd7, 8'h00);
            chk(div_ratio == VECS[i].exp_n, "R3 R4 R8 base after apply",
                div_ratio, VECS[i].exp_n);
            chk(band_high == VECS[i].hb, "R10 band flag", band_high, VECS[i].hb);
            run_window(2000, int'(VECS[i].exp_n), int'(VECS[i].exp_f), int'(VECS[i].exp_f),
                       1'b0, VECS[i].fsk, 1'b0);
        end

        // R2: shadow writes without apply leave ratio and band alone
        begin
            bit moved = 0;
            load(5'd5, 1'b1, 16'd1000, 10'd0, 8'd0);
            for (int n = 0; n < 50; n++) begin
                @(negedge clk);
                if (div_ratio != 7'd36 || band_high != 1'b0) moved = 1;
            end
            chk(!moved, "R2 no effect before apply", div_ratio, 36);
            wr(3'd7, 8'h00);
            chk(div_ratio == 7'd29, "R3 apply takes all fields", div_ratio, 29);
            chk(band_high == 1'b1, "R10 band after apply", band_high, 1);
            run_window(300, 29, 1000, 1000, 1'b0, 1'b0, 1'b0);
        end

        // R9: data bit toggling every cycle, deviation 200 around 32000
        fsk_data = 1'b0;
        load(5'd0, 1'b0, 16'd32000, 10'd0, 8'd200);
        wr(3'd7, 8'h00);
        chk(div_ratio == 7'd24, "R9 base with deviation", div_ratio, 24);
        run_window(4000, 24, 32200, 31800, 1'b1, 1'b0, 1'b0);

        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end
endmodule